// File: doc/BRIEF.md
# DS3 maintenance pattern detector

This block watches a received DS3 bit stream and raises three defect flags: alarm indication (AIS), idle signal and loss of signal (LOS). An upstream framer delivers one bit per valid strobe. With each bit it supplies markers that say whether the bit is payload or a C-bit, whether the framer is in sync, and whether the bit opens a new M-frame. Configuration inputs choose the criteria for each defect: whether an unframed all-ones stream counts as AIS, whether the C-bits must all be zero for the framed alternating-pattern AIS, the LOS polarity and enable, a programmable 4-bit idle pattern and the LOS run threshold.

The AIS and idle checks look at the payload of each whole M-frame. An M-frame is judged when the next frame boundary arrives, and the flags change only on those boundaries. LOS is a bit-level run detector that works apart from the frame structure.

Top module: `ds3_maint_detect`

## Requirements
- R1: While reset is active, and directly after it, the AIS, idle and LOS outputs are 0, and no M-frame is judged until one boundary has been seen after reset.
- R2: A frame qualifies for AIS when it is framed and its payload matches 1,0,1,0,... from the first payload bit after the boundary. A frame is framed when frame-in-sync is 1 on every bit and the frame has at least one payload bit.
- R3: An M-frame in which every valid bit is 1, overhead bits included, qualifies for AIS regardless of the frame-in-sync marker, but only while the unframed enable is 1; while it is 0, such a frame qualifies only through R2.
- R4: While C-bit ignore is 0, a single C-bit equal to 1 in an M-frame stops that frame from qualifying for AIS through the alternating pattern.
- R5: While C-bit ignore is 1, C-bit values have no effect on AIS qualification.
- R6: A framed M-frame qualifies as idle when its payload repeats the 4-bit idle pattern, most significant bit first, aligned to the first payload bit after the boundary. Programming 1100 recognises 1,1,0,0,...
- R7: Each of AIS and idle is set after HOLD_FRAMES consecutive qualifying M-frames and cleared after HOLD_FRAMES consecutive non-qualifying ones (default 2). A shorter run leaves the flag as it was.
- R8: AIS has priority: when both criteria hold, only the AIS output is 1, and the two outputs are never 1 together.
- R9: AIS and idle change only at the clock edge that samples a valid bit marked as an M-frame boundary.
- R10: While LOS detection is enabled, LOS is set at the edge that samples the threshold-th consecutive valid bit equal to the polarity input (0: zeros, 1: ones). Cycles without a valid bit neither extend nor break the run.
- R11: A valid bit of the opposite value restarts the run, and LOS is 0 after the edge that samples it.
- R12: While LOS detection is disabled, the LOS output is 0 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Received bit valid this cycle |
| bit_dat | input | 1 | Received bit value |
| is_payload | input | 1 | Bit is a payload bit |
| is_cbit | input | 1 | Bit is a C-bit |
| frm_sync | input | 1 | Upstream framer is in frame |
| mf_start | input | 1 | Bit is the first bit of an M-frame |
| cfg_ais_unframed | input | 1 | Also accept unframed all-ones as AIS |
| cfg_cbit_ignore | input | 1 | Do not require zero C-bits for AIS |
| cfg_los_ones | input | 1 | LOS polarity: 0 zeros, 1 ones |
| cfg_los_en | input | 1 | Enable LOS detection |
| cfg_idle_pat | input | 4 | Idle pattern, MSB sent first |
| cfg_los_thresh | input | 8 | LOS run length, at least 1 |
| ais_o | output | 1 | AIS defect flag |
| idle_o | output | 1 | Idle defect flag |
| los_o | output | 1 | LOS defect flag |

## Verification
The properties assume that the boundary marker means something only together with a valid strobe, and that the LOS threshold is nonzero and does not change during a run of target bits. The stimulus raises markers only on valid cycles. It changes the threshold only after reset or directly after a bit of the opposite value, and it changes the AIS and idle configuration only while reset is held. Gaps without a valid bit are placed inside frames and inside LOS runs, so that the hold-between-boundaries properties are exercised on idle cycles too.

// File: rtl/ds3md_pkg.sv
package ds3md_pkg;

  // Per-M-frame running verdicts, refreshed at every frame boundary.
  typedef struct packed {
    logic ok_alt;    // payload still matches 1,0,1,0...
    logic ok_idle;   // payload still matches the idle pattern
    logic cb_zero;   // every C-bit so far was 0
    logic no_zero;   // no zero seen on any bit
    logic in_sync;   // framer in sync on every bit
    logic any_pay;   // at least one payload bit seen
  } frm_flags_t;

  localparam frm_flags_t FLAGS_FRESH = '{ok_alt:  1'b1,
                                         ok_idle: 1'b1,
                                         cb_zero: 1'b1,
                                         no_zero: 1'b1,
                                         in_sync: 1'b1,
                                         any_pay: 1'b0};

  localparam int unsigned DEF_AIS = 0;
  localparam int unsigned DEF_IDLE = 1;
  localparam int unsigned NUM_DEF = 2;

endpackage

// File: rtl/ds3md_frame_acc.sv
module ds3md_frame_acc
  import ds3md_pkg::*;
#(
  parameter int unsigned PAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_dat,
  input  logic             is_payload,
  input  logic             is_cbit,
  input  logic             frm_sync,
  input  logic             mf_start,
  input  logic [PAT_W-1:0] cfg_idle_pat,
  input  logic             cfg_ais_unframed,
  input  logic             cfg_cbit_ignore,
  output logic             eval_stb,
  output logic             ais_qual,
  output logic             idle_qual
);

  localparam int unsigned PH_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  frm_flags_t        acc_q, acc_nxt, acc_base;
  logic [PH_W-1:0]   ph_q, ph_nxt, ph_base, pat_idx;
  logic              started_q, started_nxt;
  logic              framed;

  // Next-state: a boundary bit starts a fresh frame and is then folded in.
  always_comb begin
    acc_base = mf_start ? FLAGS_FRESH : acc_q;
    ph_base  = mf_start ? '0 : ph_q;
    pat_idx  = PH_W'(PAT_W - 1) - ph_base;
    acc_nxt  = acc_base;
    ph_nxt   = ph_base;
    if (is_payload) begin
      acc_nxt.ok_alt  = acc_base.ok_alt & (bit_dat == ~ph_base[0]);
      acc_nxt.ok_idle = acc_base.ok_idle & (bit_dat == cfg_idle_pat[pat_idx]);
      acc_nxt.any_pay = 1'b1;
      ph_nxt          = ph_base + PH_W'(1);
    end
    if (is_cbit) begin
      acc_nxt.cb_zero = acc_base.cb_zero & ~bit_dat;
    end
    acc_nxt.no_zero = acc_base.no_zero & bit_dat;
    acc_nxt.in_sync = acc_base.in_sync & frm_sync;
    started_nxt     = started_q | mf_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ph_q      <= '0;
      started_q <= 1'b0;
    end else if (bit_vld) begin
      acc_q     <= acc_nxt;
      ph_q      <= ph_nxt;
      started_q <= started_nxt;
    end
  end

  // Verdict on the frame that the current boundary bit closes.
  always_comb begin
    framed    = acc_q.in_sync & acc_q.any_pay;
    eval_stb  = bit_vld & mf_start & started_q;
    ais_qual  = (framed & acc_q.ok_alt & (cfg_cbit_ignore | acc_q.cb_zero)) |
                (cfg_ais_unframed & acc_q.no_zero);
    idle_qual = framed & acc_q.ok_idle;
  end

endmodule

// File: rtl/ds3md_integrator.sv
module ds3md_integrator #(
  parameter int unsigned HOLD_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic qual,
  output logic flag
);

  localparam int unsigned CW = (HOLD_FRAMES > 1) ? $clog2(HOLD_FRAMES) : 1;

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          flag_q, flag_nxt;

  always_comb begin
    cnt_nxt  = cnt_q;
    flag_nxt = flag_q;
    if (stb) begin
      if (qual != flag_q) begin
        if (cnt_q == CW'(HOLD_FRAMES - 1)) begin
          flag_nxt = qual;
          cnt_nxt  = '0;
        end else begin
          cnt_nxt  = cnt_q + CW'(1);
        end
      end else begin
        cnt_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (stb) begin
      cnt_q  <= cnt_nxt;
      flag_q <= flag_nxt;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/ds3md_los_run.sv
module ds3md_los_run #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_dat,
  input  logic          cfg_los_ones,
  input  logic          cfg_los_en,
  input  logic [CW-1:0] cfg_thresh,
  output logic          los
);

  logic [CW-1:0] run_q, run_nxt;
  logic          los_q, los_nxt;

  always_comb begin
    run_nxt = run_q;
    if (bit_vld) begin
      if (bit_dat == cfg_los_ones) begin
        run_nxt = (run_q >= cfg_thresh) ? run_q : run_q + CW'(1);
      end else begin
        run_nxt = '0;
      end
    end
    los_nxt = cfg_los_en & (run_nxt >= cfg_thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      los_q <= 1'b0;
    end else begin
      run_q <= run_nxt;
      los_q <= los_nxt;
    end
  end

  assign los = los_q;

endmodule

// File: rtl/ds3_maint_detect.sv
module ds3_maint_detect
  import ds3md_pkg::*;
#(
  parameter int unsigned HOLD_FRAMES = 2,
  parameter int unsigned PAT_W       = 4,
  parameter int unsigned LOS_CW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_dat,
  input  logic              is_payload,
  input  logic              is_cbit,
  input  logic              frm_sync,
  input  logic              mf_start,
  input  logic              cfg_ais_unframed,
  input  logic              cfg_cbit_ignore,
  input  logic              cfg_los_ones,
  input  logic              cfg_los_en,
  input  logic [PAT_W-1:0]  cfg_idle_pat,
  input  logic [LOS_CW-1:0] cfg_los_thresh,
  output logic              ais_o,
  output logic              idle_o,
  output logic              los_o
);

  logic               eval_stb;
  logic               ais_q, idle_q;
  logic [NUM_DEF-1:0] qual_w;
  logic [NUM_DEF-1:0] flag_w;

  ds3md_frame_acc #(.PAT_W(PAT_W)) u_acc (
    .clk              (clk),
    .rst_n            (rst_n),
    .bit_vld          (bit_vld),
    .bit_dat          (bit_dat),
    .is_payload       (is_payload),
    .is_cbit          (is_cbit),
    .frm_sync         (frm_sync),
    .mf_start         (mf_start),
    .cfg_idle_pat     (cfg_idle_pat),
    .cfg_ais_unframed (cfg_ais_unframed),
    .cfg_cbit_ignore  (cfg_cbit_ignore),
    .eval_stb         (eval_stb),
    .ais_qual         (ais_q),
    .idle_qual        (idle_q)
  );

  always_comb begin
    qual_w           = '0;
    qual_w[DEF_AIS]  = ais_q;
    qual_w[DEF_IDLE] = idle_q;
  end

  for (genvar g = 0; g < NUM_DEF; g++) begin : g_def
    ds3md_integrator #(.HOLD_FRAMES(HOLD_FRAMES)) u_int (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (eval_stb),
      .qual  (qual_w[g]),
      .flag  (flag_w[g])
    );
  end

  ds3md_los_run #(.CW(LOS_CW)) u_los (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_vld      (bit_vld),
    .bit_dat      (bit_dat),
    .cfg_los_ones (cfg_los_ones),
    .cfg_los_en   (cfg_los_en),
    .cfg_thresh   (cfg_los_thresh),
    .los          (los_o)
  );

  assign ais_o  = flag_w[DEF_AIS];
  assign idle_o = flag_w[DEF_IDLE] & ~flag_w[DEF_AIS];

endmodule

// File: rtl/ds3md_checker.sv
module ds3md_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic bit_dat,
  input logic mf_start,
  input logic cfg_los_ones,
  input logic cfg_los_en,
  input logic ais_o,
  input logic idle_o,
  input logic los_o
);

  // R8: the two pattern flags never show together
  p_ais_idle_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ais_o && idle_o));

  // R9: no boundary bit, no change of the pattern flags
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_vld && mf_start) |=> ($stable(ais_o) && $stable(idle_o)));

  // R7: AIS is only ever declared at a frame verdict
  p_ais_rise_at_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais_o) |-> $past(bit_vld && mf_start));

  // R10: a LOS declaration needs the detector enabled at that edge
  p_los_rise_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_o) |-> $past(cfg_los_en));

  // R11: an opposite bit clears LOS at once
  p_los_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && (bit_dat != cfg_los_ones)) |=> !los_o);

  // R12: disabled detector keeps LOS low
  p_los_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_los_en |=> !los_o);

endmodule

bind ds3_maint_detect ds3md_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_vld      (bit_vld),
  .bit_dat      (bit_dat),
  .mf_start     (mf_start),
  .cfg_los_ones (cfg_los_ones),
  .cfg_los_en   (cfg_los_en),
  .ais_o        (ais_o),
  .idle_o       (idle_o),
  .los_o        (los_o)
);

// File: tb/ds3_maint_detect_test.sv
`timescale 1ns/1ps
module ds3_maint_detect_test;

  localparam int N  = 2;
  localparam int FL = 48;
  localparam int K_ALT = 0, K_IDLE = 1, K_ONES = 2, K_ZERO = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_dat = 1'b0, is_payload = 1'b0, is_cbit = 1'b0;
  logic frm_sync = 1'b0, mf_start = 1'b0;
  logic cfg_ais_unframed = 1'b0, cfg_cbit_ignore = 1'b0;
  logic cfg_los_ones = 1'b0, cfg_los_en = 1'b0;
  logic [3:0] cfg_idle_pat = 4'b1100;
  logic [7:0] cfg_los_thresh = 8'd175;
  logic ais_o, idle_o, los_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ds3_maint_detect uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .is_payload(is_payload), .is_cbit(is_cbit), .frm_sync(frm_sync),
    .mf_start(mf_start), .cfg_ais_unframed(cfg_ais_unframed),
    .cfg_cbit_ignore(cfg_cbit_ignore), .cfg_los_ones(cfg_los_ones),
    .cfg_los_en(cfg_los_en), .cfg_idle_pat(cfg_idle_pat),
    .cfg_los_thresh(cfg_los_thresh), .ais_o(ais_o), .idle_o(idle_o),
    .los_o(los_o)
  );

  // ---------------- reference model ----------------
  bit pay_q[$];
  bit cb_q[$];
  bit ah[$];
  bit ih[$];
  bit m_started, m_zero_seen, m_unsync;
  bit m_ais, m_idle, m_los;
  int m_run;

  task automatic judge_frame();
    bit framed, alt_ok, idle_ok, cz, a_q, i_q, same;
    framed = !m_unsync && (pay_q.size() > 0);
    alt_ok = 1; idle_ok = 1; cz = 1;
    for (int i = 0; i < pay_q.size(); i++) begin
      if (pay_q[i] != ((i % 2) == 0)) alt_ok = 0;
      if (pay_q[i] != cfg_idle_pat[3 - (i % 4)]) idle_ok = 0;
    end
    for (int i = 0; i < cb_q.size(); i++) if (cb_q[i]) cz = 0;
    a_q = (framed && alt_ok && (cfg_cbit_ignore || cz)) ||
          (cfg_ais_unframed && !m_zero_seen);
    i_q = framed && idle_ok;
    ah.push_back(a_q); if (ah.size() > N) void'(ah.pop_front());
    ih.push_back(i_q); if (ih.size() > N) void'(ih.pop_front());
    if (ah.size() == N) begin
      same = 1;
      for (int i = 0; i < N; i++) if (ah[i] != a_q) same = 0;
      if (same) m_ais = a_q;
    end
    if (ih.size() == N) begin
      same = 1;
      for (int i = 0; i < N; i++) if (ih[i] != i_q) same = 0;
      if (same) m_idle = i_q;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pay_q.delete(); cb_q.delete(); ah.delete(); ih.delete();
      m_started = 0; m_zero_seen = 0; m_unsync = 0;
      m_ais = 0; m_idle = 0; m_los = 0; m_run = 0;
    end else begin
      if (bit_vld) begin
        if (mf_start) begin
          if (m_started) judge_frame();
          pay_q.delete(); cb_q.delete();
          m_zero_seen = 0; m_unsync = 0; m_started = 1;
        end
        if (is_payload) pay_q.push_back(bit_dat);
        if (is_cbit) cb_q.push_back(bit_dat);
        if (!bit_dat) m_zero_seen = 1;
        if (!frm_sync) m_unsync = 1;
        if (bit_dat == cfg_los_ones) m_run++; else m_run = 0;
      end
      m_los = cfg_los_en && (m_run >= int'(cfg_los_thresh));
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ais_o == m_ais, "R2", "model ais", ais_o, m_ais);
      chk(idle_o == (m_idle && !m_ais), "R6", "model idle", idle_o, m_idle && !m_ais);
      chk(los_o == m_los, "R10", "model los", los_o, m_los);
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_vld = 0; mf_start = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_bit(input bit d, input bit pay, input bit cb,
                          input bit sy, input bit ms);
    bit_vld = 1; bit_dat = d; is_payload = pay; is_cbit = cb;
    frm_sync = sy; mf_start = ms;
    @(negedge clk);
    bit_vld = 0; mf_start = 0; is_payload = 0; is_cbit = 0;
  endtask

  task automatic gap();
    bit_vld = 0;
    @(negedge clk);
  endtask

  task automatic send_frame(input int kind, input bit [3:0] pg,
                            input bit cv, input bit sy);
    int k = 0;
    for (int p = 0; p < FL; p++) begin
      bit ov, cb, d;
      ov = (p % 12) == 0;
      cb = ov && (p != 0);
      case (kind)
        K_ALT:  d = ov ? (cb ? cv : 1'b1) : ((k % 2) == 0);
        K_IDLE: d = ov ? (cb ? cv : 1'b1) : pg[3 - (k % 4)];
        K_ONES: d = 1'b1;
        default: d = ov ? (cb ? cv : 1'b1) : 1'b0;
      endcase
      send_bit(d, !ov, cb, sy, p == 0);
      if (!ov) k++;
      if (p == 30) gap();
    end
  endtask

  task automatic frames(input int n, input int kind, input bit [3:0] pg,
                        input bit cv, input bit sy);
    for (int i = 0; i < n; i++) send_frame(kind, pg, cv, sy);
  endtask

  task automatic expect_flags(input string req, input bit ea, input bit ei);
    chk(ais_o == ea, req, "ais_o", ais_o, ea);
    chk(idle_o == ei, req, "idle_o", idle_o, ei);
  endtask

  task automatic send_run(input int n, input bit d);
    for (int i = 0; i < n; i++) begin
      send_bit(d, 0, 0, 0, 0);
      if (i == 9) gap();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ais_o == 0 && idle_o == 0 && los_o == 0, "R1", "flags in reset",
        {ais_o, idle_o, los_o}, 0);
    rst_n = 1;
    @(negedge clk);
    expect_flags("R1", 0, 0);

    // R2: framed 1010, zero C-bits
    frames(3, K_ALT, 4'b0, 0, 1);
    expect_flags("R2", 1, 0);
    // R9: mid-frame the flag holds
    for (int p = 0; p < 20; p++) send_bit(0, 1, 0, 1, p == 0);
    expect_flags("R9", 1, 0);
    do_reset();
    @(negedge clk);
    expect_flags("R1", 0, 0);

    // R7: declare and clear need N frames
    frames(2, K_ALT, 4'b0, 0, 1);
    expect_flags("R7", 0, 0);
    frames(1, K_ALT, 4'b0, 0, 1);
    expect_flags("R7", 1, 0);
    frames(2, K_ZERO, 4'b0, 0, 1);
    expect_flags("R7", 1, 0);
    frames(1, K_ZERO, 4'b0, 0, 1);
    expect_flags("R7", 0, 0);

    // R4: a set C-bit blocks AIS
    do_reset();
    frames(3, K_ALT, 4'b0, 1, 1);
    expect_flags("R4", 0, 0);

    // R5: C-bits ignored
    do_reset();
    cfg_cbit_ignore = 1;
    frames(3, K_ALT, 4'b0, 1, 1);
    expect_flags("R5", 1, 0);

    // R3: unframed all-ones
    do_reset();
    cfg_cbit_ignore = 0;
    frames(3, K_ONES, 4'b0, 1, 0);
    expect_flags("R3", 0, 0);
    do_reset();
    cfg_ais_unframed = 1;
    frames(3, K_ONES, 4'b0, 1, 0);
    expect_flags("R3", 1, 0);

    // R2: out-of-sync alternating payload does not qualify
    do_reset();
    cfg_ais_unframed = 0; cfg_cbit_ignore = 1;
    frames(3, K_ALT, 4'b0, 0, 0);
    expect_flags("R2", 0, 0);
    frames(3, K_IDLE, 4'b1100, 0, 0);
    expect_flags("R6", 0, 0);

    // R6: idle pattern recognition
    do_reset();
    cfg_cbit_ignore = 0; cfg_idle_pat = 4'b1100;
    frames(3, K_IDLE, 4'b1100, 0, 1);
    expect_flags("R6", 0, 1);
    do_reset();
    cfg_idle_pat = 4'b1001;
    frames(3, K_IDLE, 4'b1001, 1, 1);
    expect_flags("R6", 0, 1);
    do_reset();
    cfg_idle_pat = 4'b0110;
    frames(3, K_IDLE, 4'b1100, 0, 1);
    expect_flags("R6", 0, 0);

    // R8: both criteria true, AIS wins
    do_reset();
    cfg_idle_pat = 4'b1010;
    frames(3, K_ALT, 4'b0, 0, 1);
    expect_flags("R8", 1, 0);

    // LOS
    do_reset();
    cfg_los_en = 1; cfg_los_ones = 0; cfg_los_thresh = 8'd20;
    send_run(19, 0);
    chk(los_o == 0, "R10", "los before threshold", los_o, 0);
    send_run(1, 0);
    chk(los_o == 1, "R10", "los at threshold zeros", los_o, 1);
    send_run(1, 1);
    chk(los_o == 0, "R11", "los cleared by one", los_o, 0);
    cfg_los_ones = 1;
    send_run(19, 1);
    chk(los_o == 0, "R10", "los before threshold ones", los_o, 0);
    send_run(1, 1);
    chk(los_o == 1, "R10", "los at threshold ones", los_o, 1);
    send_run(1, 0);
    chk(los_o == 0, "R11", "los cleared by zero", los_o, 0);
    cfg_los_ones = 0; cfg_los_thresh = 8'd175;
    send_run(174, 0);
    chk(los_o == 0, "R10", "los before 175", los_o, 0);
    send_run(1, 0);
    chk(los_o == 1, "R10", "los at 175", los_o, 1);
    cfg_los_en = 0;
    @(negedge clk);
    chk(los_o == 0, "R12", "los disabled", los_o, 0);
    send_run(5, 0);
    chk(los_o == 0, "R12", "los disabled during zeros", los_o, 0);
    cfg_los_en = 1;
    @(negedge clk);
    chk(los_o == 1, "R10", "los re-enabled", los_o, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule